// File: doc/BRIEF.md
# Hex Record Printer

This block turns a small binary record into a printable line of text. A record carries a 32-bit value, an 8-bit value and a 6-bit value. The block sends the record, one character at a time, to a character sink such as the transmit FIFO of a serial port. Each character is an ASCII hexadecimal digit. The line is always twelve digits long and ends with a newline.

The record is first packed into a six-byte buffer. The lowest byte holds the 6-bit value with two zero bits above it. The next byte holds the 8-bit value. The top four bytes hold the 32-bit value, least significant byte lowest. The buffer is then walked from its top byte down to its bottom byte, upper nibble before lower nibble. The printed line therefore reads: the 32-bit value as 8 digits, then the 8-bit value as 2 digits, then the padded 6-bit value as 2 digits.

Both sides use valid/ready handshakes. The block takes a new record only when it is idle. When the character sink stops accepting, the block holds its current character, and the record input then stays refused. A full sink therefore stalls the upstream logic, and no character is dropped or repeated.

Top module: `hex_record_printer`

## Requirements
- R1: After reset the block is idle, with `rec_ready_o` = 1 and `chr_valid_o` = 0.
- R2: A record is taken only on a cycle where `rec_valid_i` and `rec_ready_o` are both 1. While a line is being printed, `rec_ready_o` is 0, and a record offered in that time has no effect on the characters printed.
- R3: The first 8 characters of a line are the 32-bit field in hexadecimal, most significant nibble first.
- R4: Characters 9 and 10 of a line are the 8-bit field in hexadecimal, upper nibble first.
- R5: Characters 11 and 12 of a line are the byte {2'b00, 6-bit field} in hexadecimal. Because of the two zero bits, character 11 is always '0' to '3'.
- R6: A nibble value of 0 to 9 is sent as 0x30 to 0x39. A nibble value of 10 to 15 is sent as 0x41 to 0x46 (uppercase 'A' to 'F').
- R7: Character 13 of a line is a newline (0x0A). In the cycle after the newline is accepted, the block is idle again with `rec_ready_o` = 1, so the next record can be taken at once.
- R8: While `chr_valid_o` = 1 and `chr_ready_i` = 0, the next cycle still has `chr_valid_o` = 1 and the same `chr_data_o`. Each character is sent exactly once, no matter how the sink stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rec_valid_i | input | 1 | A record is offered |
| rec_ready_o | output | 1 | The block is idle and takes a record |
| rec_word_i | input | 32 | 32-bit field of the record |
| rec_byte_i | input | 8 | 8-bit field of the record |
| rec_tag_i | input | 6 | 6-bit field of the record |
| chr_valid_o | output | 1 | A character is presented to the sink |
| chr_ready_i | input | 1 | The sink accepts the character |
| chr_data_o | output | 8 | ASCII character |

## Verification
A wrong character counter shows at the ports within one accepted character. The character sent is then a digit from the wrong nibble, a newline comes too early or too late, or a digit is skipped or repeated. A buffer that is reloaded while busy changes the digits of the line being printed. The bench therefore offers other records during every print and compares each character of the line. A bad stall path shows as a character that changes, or goes invalid, in the cycle after a refused transfer.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
  localparam logic [7:0] NEWLINE = 8'h0A;

  // nibble to uppercase ASCII hex digit
  function automatic logic [7:0] nib_to_ascii(input logic [3:0] n);
    logic [7:0] r;
    if (n < 4'd10) r = 8'h30 + {4'h0, n};
    else           r = 8'h37 + {4'h0, n};
    return r;
  endfunction
endpackage

// File: rtl/hrp_pack.sv
module hrp_pack #(
  parameter int WORD_W = 32,
  parameter int FLD_W  = 8,
  parameter int TAG_W  = 6,
  localparam int WORD_BYTES = WORD_W / 8,
  localparam int NBYTE  = WORD_BYTES + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [WORD_W-1:0]  word_i,
  input  logic [FLD_W-1:0]   fld_i,
  input  logic [TAG_W-1:0]   tag_i,
  output logic [NBYTE*8-1:0] buf_o
);
  logic [NBYTE*8-1:0] packed_w;

  // byte 0: padded tag, byte 1: field, bytes 2.. : word, low byte first
  assign packed_w[7:0]  = {{(8-TAG_W){1'b0}}, tag_i};
  assign packed_w[15:8] = fld_i;
  for (genvar i = 0; i < WORD_BYTES; i++) begin : g_word
    assign packed_w[(i+2)*8 +: 8] = word_i[i*8 +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     buf_o <= '0;
    else if (load_i) buf_o <= packed_w;
  end
endmodule

// File: rtl/hrp_seq.sv
module hrp_seq #(
  parameter int NCHAR = 12,
  localparam int IDX_W = $clog2(NCHAR + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rec_valid_i,
  input  logic             chr_ready_i,
  output logic             rec_ready_o,
  output logic             chr_valid_o,
  output logic             load_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NCHAR);

  logic busy_q;
  logic [IDX_W-1:0] idx_q;
  logic xfer;

  assign rec_ready_o = !busy_q;
  assign chr_valid_o = busy_q;
  assign load_o      = rec_valid_i && !busy_q;
  assign xfer        = busy_q && chr_ready_i;
  assign idx_o       = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (load_o) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (xfer) begin
      if (idx_q == LAST) busy_q <= 1'b0;
      else               idx_q  <= idx_q + 1'b1;
    end
  end

  a_r2_load_starts_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> chr_valid_o && idx_o == '0);
  a_r8_idx_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chr_valid_o && !chr_ready_i |=> $stable(idx_o));
endmodule

// File: rtl/hrp_hex_enc.sv
module hrp_hex_enc #(
  parameter int NBYTE = 6,
  localparam int NCHAR = NBYTE * 2,
  localparam int IDX_W = $clog2(NCHAR + 1)
) (
  input  logic [NBYTE*8-1:0] buf_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [7:0]         chr_o
);
  import hrp_pkg::*;

  logic [3:0] nib;

  // char k takes nibble NCHAR-1-k of the flat buffer: top byte first, upper nibble first
  always_comb begin
    nib = '0;
    for (int k = 0; k < NCHAR; k++) begin
      if (idx_i == IDX_W'(k)) nib = buf_i[(NCHAR-1-k)*4 +: 4];
    end
    chr_o = (idx_i == IDX_W'(NCHAR)) ? NEWLINE : nib_to_ascii(nib);
  end
endmodule

// File: rtl/hex_record_printer.sv
module hex_record_printer #(
  parameter int WORD_W = 32,
  parameter int FLD_W  = 8,
  parameter int TAG_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rec_valid_i,
  output logic              rec_ready_o,
  input  logic [WORD_W-1:0] rec_word_i,
  input  logic [FLD_W-1:0]  rec_byte_i,
  input  logic [TAG_W-1:0]  rec_tag_i,
  output logic              chr_valid_o,
  input  logic              chr_ready_i,
  output logic [7:0]        chr_data_o
);
  localparam int NBYTE = WORD_W / 8 + 2;
  localparam int NCHAR = NBYTE * 2;
  localparam int IDX_W = $clog2(NCHAR + 1);

  logic             load_w;
  logic [IDX_W-1:0] idx_w;
  logic [NBYTE*8-1:0] buf_w;

  hrp_seq #(.NCHAR(NCHAR)) u_seq (
    .clk_i, .rst_ni, .rec_valid_i, .chr_ready_i,
    .rec_ready_o, .chr_valid_o,
    .load_o(load_w), .idx_o(idx_w)
  );

  hrp_pack #(.WORD_W(WORD_W), .FLD_W(FLD_W), .TAG_W(TAG_W)) u_pack (
    .clk_i, .rst_ni, .load_i(load_w),
    .word_i(rec_word_i), .fld_i(rec_byte_i), .tag_i(rec_tag_i),
    .buf_o(buf_w)
  );

  hrp_hex_enc #(.NBYTE(NBYTE)) u_enc (
    .buf_i(buf_w), .idx_i(idx_w), .chr_o(chr_data_o)
  );

  a_r8_hold_char: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chr_valid_o && !chr_ready_i |=> chr_valid_o && $stable(chr_data_o));
  a_r7_idle_after_nl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chr_valid_o && chr_ready_i && chr_data_o == 8'h0A |=> rec_ready_o);
  a_r6_hex_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chr_valid_o |-> (chr_data_o >= 8'h30 && chr_data_o <= 8'h39) ||
                    (chr_data_o >= 8'h41 && chr_data_o <= 8'h46) || chr_data_o == 8'h0A);
  a_r5_pad_digit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chr_valid_o && idx_w == IDX_W'(NCHAR-2) |-> chr_data_o >= 8'h30 && chr_data_o <= 8'h33);
  a_r2_no_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chr_valid_o && !(chr_ready_i && chr_data_o == 8'h0A) |=> $stable(buf_w));
endmodule

// File: tb/hex_record_printer_tb.sv
`timescale 1ns/1ps
module hex_record_printer_tb;
  logic clk = 0, rst_n = 0;
  logic rec_valid = 0, chr_ready = 0;
  logic [31:0] rec_word = '0;
  logic [7:0]  rec_byte = '0;
  logic [5:0]  rec_tag = '0;
  logic rec_ready, chr_valid;
  logic [7:0] chr_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hex_record_printer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rec_valid_i(rec_valid), .rec_ready_o(rec_ready),
    .rec_word_i(rec_word), .rec_byte_i(rec_byte), .rec_tag_i(rec_tag),
    .chr_valid_o(chr_valid), .chr_ready_i(chr_ready), .chr_data_o(chr_data)
  );

  // {word, byte, tag, stall mode}
  localparam int NV = 6;
  localparam logic [47:0] VEC [NV] = '{
    {32'h0123_4567, 8'h89, 6'h3F, 2'd0},
    {32'h89AB_CDEF, 8'hFE, 6'h00, 2'd1},
    {32'h0000_0000, 8'h00, 6'h2A, 2'd2},
    {32'hFFFF_FFFF, 8'hA5, 6'h15, 2'd3},
    {32'hDEAD_BEEF, 8'h3C, 6'h30, 2'd1},
    {32'h1020_3040, 8'h7B, 6'h0F, 2'd0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] asc(input logic [3:0] n);
    return (n <= 9) ? (8'd48 + 8'(n)) : (8'd65 + 8'(n) - 8'd10);
  endfunction

  function automatic logic [7:0] exp_chr(input logic [31:0] w, input logic [7:0] b,
                                         input logic [5:0] t, input int k);
    logic [3:0] n;
    if (k < 8)        n = 4'(w >> (28 - 4*k));
    else if (k == 8)  n = b[7:4];
    else if (k == 9)  n = b[3:0];
    else if (k == 10) n = {2'b00, t[5:4]};
    else if (k == 11) n = t[3:0];
    else return 8'h0A;
    return asc(n);
  endfunction

  function automatic string req_of(input int k);
    if (k < 8)  return "R3 R6";
    if (k < 10) return "R4 R6";
    if (k < 12) return "R5 R6";
    return "R7";
  endfunction

  function automatic bit rdy(input int mode, input int cyc);
    case (mode)
      0: return 1'b1;
      1: return cyc[0];
      2: return cyc >= 4;
      default: return ((cyc * 7 + 3) % 5) > 1;
    endcase
  endfunction

  task automatic print_one(input logic [31:0] w, input logic [7:0] b,
                           input logic [5:0] t, input int mode);
    int k = 0;
    int cyc = 0;
    bit prev_stall = 0;
    logic [7:0] prev_d = '0;
    @(negedge clk);
    check(rec_ready === 1'b1, "R7 idle before record", rec_ready, 1);
    rec_valid = 1; rec_word = w; rec_byte = b; rec_tag = t;
    chr_ready = 0;
    @(negedge clk);
    // junk record offered during the whole line
    rec_word = ~w; rec_byte = ~b; rec_tag = ~t;
    while (k < 13 && cyc < 1000) begin
      if (prev_stall)
        check(chr_valid === 1'b1 && chr_data === prev_d, "R8 held under stall", chr_data, prev_d);
      if (cyc == 1) check(rec_ready === 1'b0, "R2 refused while busy", rec_ready, 0);
      chr_ready = rdy(mode, cyc);
      if (chr_valid && chr_ready) begin
        check(chr_data === exp_chr(w, b, t, k), req_of(k), chr_data, exp_chr(w, b, t, k));
        if (k == 12) rec_valid = 0;
        k++;
      end
      prev_stall = chr_valid && !chr_ready;
      prev_d = chr_data;
      cyc++;
      @(negedge clk);
    end
    chr_ready = 0;
    if (k < 13) check(0, "R8 line incomplete", k, 13);
    check(rec_ready === 1'b1 && chr_valid === 1'b0, "R7 idle after newline", rec_ready, 1);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rec_ready === 1'b1, "R1 rec_ready in reset", rec_ready, 1);
    check(chr_valid === 1'b0, "R1 chr_valid in reset", chr_valid, 0);
    rst_n = 1;
    @(negedge clk);
    check(rec_ready === 1'b1 && chr_valid === 1'b0, "R1 idle after reset", chr_valid, 0);
    // no record offered: stays idle
    repeat (3) @(negedge clk);
    check(chr_valid === 1'b0, "R2 no record no output", chr_valid, 0);

    for (int i = 0; i < NV; i++)
      print_one(VEC[i][47:16], VEC[i][15:8], VEC[i][7:2], int'(VEC[i][1:0]));

    // back-to-back corner: all-letter digits, long stall at start
    print_one(32'hABCD_EFAB, 8'hCD, 6'h3E, 2);
    print_one(32'h9999_0000, 8'h09, 6'h01, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule